// File: doc/BRIEF.md
# Memory test traffic generator

This block drives a memory controller through a request/response master port and checks it. A start pulse in the idle state begins a test. The block first writes a pseudo-random word to every address, in ascending order. It then reads every address back in the same order and compares each returned word with the same pseudo-random sequence, generated again from the same seed. While a test runs, a busy flag is high. A saturating error counter records the mismatches. Three capture outputs hold the address, the returned word and the expected word of the most recent mismatch.

Requests use valid/ready handshaking. Read data comes back later on a separate strobe, in issue order, and any number of reads may be outstanding. Because the responses are in order, a response address counter pairs each one with its address.

The control FSM has four states: `ST_IDLE`, `ST_WRITE`, `ST_READ` and `ST_DRAIN`. The transitions are:
- `ST_IDLE`→`ST_WRITE` on an accepted start.
- `ST_WRITE`→`ST_READ` when the write to the highest address is accepted.
- `ST_READ`→`ST_DRAIN` when the read of the highest address is accepted.
- `ST_DRAIN`→`ST_IDLE` when the response for the highest address is checked.

Top module: `memtest_gen`

## Requirements
- R1: While synchronous reset `rst` is high, and on the cycle after it is released, the outputs are as follows: `busy_o`, `mem_valid_o`, `err_count_o`, `fail_addr_o`, `fail_rdata_o` and `fail_exp_o` are all 0.
- R2: A `start_i` sampled high while idle raises `busy_o` at that same edge and clears `err_count_o` to 0.
- R3: The write pass issues exactly one accepted write (`mem_we_o`=1) per address, ascending from 0 to 2^ADDR_W-1. All writes are accepted before any read is issued. While `mem_valid_o` is high and `mem_ready_i` is low, the address, data and direction of the request stay unchanged.
- R4: The word written to address k is the k-th state of a right-shifting Galois LFSR. Address 0 gets the seed 0xACE1. The next state is (s>>1) XOR (s[0] ? 0xB400 : 0).
- R5: The read pass issues one accepted read (`mem_we_o`=0) per address, ascending from 0. The n-th response is compared with the word of R4 for address n.
- R6: `err_count_o` rises by one for each mismatching response and saturates at 2^ERR_W-1.
- R7: On a mismatch, `fail_addr_o`, `fail_rdata_o` and `fail_exp_o` take the address, the returned word and the expected word. They hold these values until the next mismatch. A new start does not change them.
- R8: `busy_o` stays high until the last response has been checked and falls at the edge that samples it.
- R9: A `start_i` pulse while `busy_o` is high has no effect. The test neither restarts nor clears its count.
- R10: Read responses may arrive any number of cycles after acceptance while other reads are still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a test (idle only) |
| mem_valid_o | output | 1 | Request valid |
| mem_ready_i | input | 1 | Request accepted when high with valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Request address |
| mem_wdata_o | output | DATA_W | Write word |
| mem_rvalid_i | input | 1 | Read response strobe |
| mem_rdata_i | input | DATA_W | Read response word |
| busy_o | output | 1 | Test in progress |
| err_count_o | output | ERR_W | Saturating mismatch count |
| fail_addr_o | output | ADDR_W | Address of last mismatch |
| fail_rdata_o | output | DATA_W | Returned word of last mismatch |
| fail_exp_o | output | DATA_W | Expected word of last mismatch |

## Verification
Most results register one edge after the stimulus. `busy_o` rises at the edge that samples `start_i`. The count and the captures change at the edge that samples `mem_rvalid_i`. `busy_o` falls at the edge that samples the final response. The bench drives inputs and samples outputs on the falling edge, so each check reads its value half a cycle after the responsible rising edge. The bench's memory model checks each accepted request at the edge where it is accepted. It returns read data two edges later while the ready pattern stalls requests. This keeps several reads in flight.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DRAIN = 2'd3
    } mt_state_e;
endpackage

// File: rtl/memtest_lfsr.sv
module memtest_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] s_q;

    always_ff @(posedge clk) begin
        if (rst || load_i)
            s_q <= SEED;
        else if (step_i)
            s_q <= (s_q >> 1) ^ (s_q[0] ? TAPS : '0);
    end

    assign state_o = s_q;

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        s_q != '0); // R4
endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              rvalid_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [ERR_W-1:0]  err_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_rdata_o,
    output logic [DATA_W-1:0] fail_exp_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic              miss;
    logic [ERR_W-1:0]  err_q;
    logic [ADDR_W-1:0] fa_q;
    logic [DATA_W-1:0] fr_q, fe_q;

    assign miss = rvalid_i && (rdata_i != exp_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (clr_i) begin
            err_q <= '0;
        end else if (miss && err_q != ERR_MAX) begin
            err_q <= err_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q <= '0;
            fr_q <= '0;
            fe_q <= '0;
        end else if (miss) begin
            fa_q <= raddr_i;
            fr_q <= rdata_i;
            fe_q <= exp_i;
        end
    end

    assign err_o        = err_q;
    assign fail_addr_o  = fa_q;
    assign fail_rdata_o = fr_q;
    assign fail_exp_o   = fe_q;

    AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> err_q >= $past(err_q)); // R6
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> err_q - $past(err_q) <= 1); // R6
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !miss |=> $stable(fa_q) && $stable(fr_q) && $stable(fe_q)); // R7
endmodule

// File: rtl/memtest_gen.sv
module memtest_gen
    import memtest_pkg::*;
#(
    parameter int           ADDR_W = 6,
    parameter int           DATA_W = 16,
    parameter int           ERR_W  = 8,
    parameter logic [DATA_W-1:0] TAPS = 16'hB400,
    parameter logic [DATA_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic [ERR_W-1:0]  err_count_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_rdata_o,
    output logic [DATA_W-1:0] fail_exp_o
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    mt_state_e         state_q, state_d;
    logic [ADDR_W-1:0] iss_q, rsp_q;
    logic              go, accept, rsp_ok, wr_done, rd_issued, rd_done;
    logic [DATA_W-1:0] wr_word, exp_word;

    assign go        = start_i && (state_q == ST_IDLE);
    assign accept    = mem_valid_o && mem_ready_i;
    assign rsp_ok    = mem_rvalid_i && (state_q == ST_READ || state_q == ST_DRAIN);
    assign wr_done   = (state_q == ST_WRITE) && accept && (iss_q == ADDR_LAST);
    assign rd_issued = (state_q == ST_READ) && accept && (iss_q == ADDR_LAST);
    assign rd_done   = rsp_ok && (rsp_q == ADDR_LAST);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)        state_d = ST_WRITE;
            ST_WRITE: if (wr_done)   state_d = ST_READ;
            ST_READ:  if (rd_issued) state_d = ST_DRAIN;
            ST_DRAIN: if (rd_done)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // address counters
    always_ff @(posedge clk) begin
        if (rst || go) begin
            iss_q <= '0;
            rsp_q <= '0;
        end else begin
            if (accept) iss_q <= iss_q + 1'b1;
            if (rsp_ok) rsp_q <= rsp_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_valid_o = 1'b0;
        mem_we_o    = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_WRITE: begin mem_valid_o = 1'b1; mem_we_o = 1'b1; end
            ST_READ:  mem_valid_o = 1'b1;
            ST_DRAIN: ;
            default:  busy_o = 1'b0;
        endcase
    end

    assign mem_addr_o  = iss_q;
    assign mem_wdata_o = wr_word;

    memtest_lfsr #(.W(DATA_W), .TAPS(TAPS), .SEED(SEED)) u_wr_lfsr (
        .clk(clk), .rst(rst), .load_i(go),
        .step_i((state_q == ST_WRITE) && accept), .state_o(wr_word));

    memtest_lfsr #(.W(DATA_W), .TAPS(TAPS), .SEED(SEED)) u_rd_lfsr (
        .clk(clk), .rst(rst), .load_i(wr_done),
        .step_i(rsp_ok), .state_o(exp_word));

    memtest_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_cmp (
        .clk(clk), .rst(rst), .clr_i(go),
        .rvalid_i(rsp_ok), .rdata_i(mem_rdata_i), .exp_i(exp_word), .raddr_i(rsp_q),
        .err_o(err_count_o), .fail_addr_o(fail_addr_o),
        .fail_rdata_o(fail_rdata_o), .fail_exp_o(fail_exp_o));

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_valid_o); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)); // R3
    AST_NO_REWRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ || state_q == ST_DRAIN) |=> state_q != ST_WRITE); // R9
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(mem_rvalid_i)); // R8
endmodule

// File: tb/memtest_gen_tb.sv
`timescale 1ns/1ps
module memtest_gen_tb;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int EW = 4;
    localparam int N  = 1 << AW;
    localparam logic [DW-1:0] MASK = 16'h0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic valid, ready, we, rvalid, busy;
    logic [AW-1:0] addr, faddr;
    logic [DW-1:0] wdata, rdata, frd, fex;
    logic [EW-1:0] errc;

    int n_vec = 0, n_bad = 0;
    int wr_cnt, rd_cnt, resp_seen, cyc;
    logic clr_cnt = 1'b0;
    logic [DW-1:0] mem [N];
    logic bad [N];
    logic p1_v;
    logic [DW-1:0] p1_d;

    always #2.5 clk = ~clk;

    memtest_gen #(.ADDR_W(AW), .DATA_W(DW), .ERR_W(EW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start),
        .mem_valid_o(valid), .mem_ready_i(ready), .mem_we_o(we),
        .mem_addr_o(addr), .mem_wdata_o(wdata),
        .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
        .busy_o(busy), .err_count_o(errc),
        .fail_addr_o(faddr), .fail_rdata_o(frd), .fail_exp_o(fex));

    function automatic logic [DW-1:0] exp_at(int k);
        logic [DW-1:0] s = 16'hACE1;
        for (int i = 0; i < k; i++) s = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // memory model: ready pattern, 2-edge read latency, in-order responses
    always @(posedge clk) begin
        cyc <= cyc + 1;
        ready <= (cyc % 4) != 1;
        if (rvalid) resp_seen <= resp_seen + 1;
        rvalid <= p1_v;
        rdata  <= p1_d;
        p1_v   <= 1'b0;
        if (clr_cnt) begin
            wr_cnt <= 0; rd_cnt <= 0; resp_seen <= 0;
        end else if (valid && ready) begin
            if (we) begin
                chk(addr == wr_cnt[AW-1:0] && wr_cnt < N, "R3", "write address", addr, wr_cnt);
                chk(rd_cnt == 0, "R3", "write after read", rd_cnt, 0);
                chk(wdata == exp_at(int'(addr)), "R4", "write data", wdata, exp_at(int'(addr)));
                mem[addr] <= wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                chk(addr == rd_cnt[AW-1:0] && rd_cnt < N, "R5", "read address", addr, rd_cnt);
                chk(wr_cnt == N, "R3", "writes before read", wr_cnt, N);
                p1_v <= 1'b1;
                p1_d <= mem[addr] ^ (bad[addr] ? MASK : '0);
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic run(input bool_mid, input int stop_guard);
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        chk(errc == 0, "R2", "count cleared at start", errc, 0);
        for (int i = 0; i < stop_guard; i++) begin
            @(negedge clk);
            if (bool_mid && i == 40) start = 1'b1;   // R9 stimulus
            else start = 1'b0;
            if (resp_seen == N) break;
            if (!busy) begin
                chk(0, "R8", "busy fell early", resp_seen, N);
                break;
            end
        end
        start = 1'b0;
        chk(busy == 1'b0, "R8", "busy after last response", busy, 0);
        chk(wr_cnt == N, "R9", "writes per run", wr_cnt, N);
        chk(rd_cnt == N, "R5", "reads per run", rd_cnt, N);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", "no restart", busy, 0);
    endtask

    initial begin
        #(200000 * 5);
        chk(0, "WD", "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cyc = 0; wr_cnt = 0; rd_cnt = 0; resp_seen = 0;
        p1_v = 0; p1_d = '0; rvalid = 0; rdata = '0; ready = 0;
        for (int i = 0; i < N; i++) begin bad[i] = 1'b0; mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!busy && !valid && errc == 0, "R1", "reset idle", {busy, valid, errc}, 0);
        chk(faddr == 0 && frd == 0 && fex == 0, "R1", "reset captures", {faddr, frd, fex}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !valid, "R1", "idle after release", {busy, valid}, 0);

        // clean pass (R10: stalls and pipelined reads from the model)
        run(1'b0, 2000);
        chk(errc == 0, "R5", "clean errors", errc, 0);
        chk(faddr == 0 && frd == 0 && fex == 0, "R7", "captures untouched", faddr, 0);

        // two faults, start pulse while busy
        bad[5] = 1'b1; bad[40] = 1'b1;
        run(1'b1, 2000);
        chk(errc == 2, "R6", "two mismatches", errc, 2);
        chk(errc == 2, "R9", "mid start no clear", errc, 2);
        chk(faddr == 40, "R7", "fail address", faddr, 40);
        chk(fex == exp_at(40), "R7", "fail expected", fex, exp_at(40));
        chk(frd == (exp_at(40) ^ MASK), "R7", "fail read data", frd, exp_at(40) ^ MASK);

        // all faulty: saturation
        for (int i = 0; i < N; i++) bad[i] = 1'b1;
        run(1'b0, 2000);
        chk(errc == 15, "R6", "saturated count", errc, 15);
        chk(faddr == N - 1, "R7", "last fail address", faddr, N - 1);
        chk(fex == exp_at(N - 1), "R4", "expected at top address", fex, exp_at(N - 1));

        // clean again: count cleared, captures held
        for (int i = 0; i < N; i++) bad[i] = 1'b0;
        run(1'b0, 2000);
        chk(errc == 0, "R2", "count cleared by new start", errc, 0);
        chk(faddr == N - 1 && fex == exp_at(N - 1), "R7", "captures held", faddr, N - 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule